// File: doc/BRIEF.md
# Framed 24-bit serial command receiver

This block takes write-only frames from a three-wire serial link: an active-low frame select, a serial clock and a data line. All three pins are oversampled by the faster system clock. Edges are found inside the system-clock domain. A frame opens when select falls. After that, one data bit is taken on each falling edge of the serial clock, most significant bit first. When exactly 24 bits have arrived, the frame is complete and the block issues one command toward downstream logic.

Each command carries three fields: a 3-bit opcode, a 3-bit channel address and a 16-bit data word. The two leading bits of the frame are discarded.

A frame is voided in two cases: select rises before the 24th falling edge, or the abort input is raised. A voided frame issues nothing and leaves no partial data behind. Completion depends only on the 24th falling edge. Once a frame has completed, select may stay low or rise, and further clock edges are ignored. The next frame needs select to rise and then fall again.

Top module: `sfr_cmd_rx`

## Requirements
- R1: After reset, `cmd_valid` is 0 and `cmd_code`, `cmd_addr` and `cmd_data` are all zero.
- R2: Data bits are taken only on falling edges of the serial clock (a 1-to-0 change of the synchronized `sclk_pin`), first bit in being frame bit 23. Rising edges take no data.
- R3: Frame bits 21:19 appear on `cmd_code`, bits 18:16 on `cmd_addr` and bits 15:0 on `cmd_data`. Bits 23:22 affect no output.
- R4: `cmd_valid` is high for exactly one system cycle per completed frame. That cycle follows by three system-clock edges the first edge at which the 24th serial-clock fall is sampled on the pins.
- R5: If `sel_n_pin` rises before the 24th falling edge, no command is issued for that frame.
- R6: A high `abort` during a frame voids it in the same way as an early select rise.
- R7: After the 24th falling edge, further serial-clock edges with select still low issue no further command.
- R8: Only a 1-to-0 change of select opens a frame. Serial-clock edges while select is high, or while select is low after a void or a completion, issue nothing.
- R9: A voided frame leaves no residue: the next complete frame decodes exactly its own 24 bits.
- R10: While `cmd_valid` is low, the three field outputs hold the values of the last issued command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_pin | input | 1 | Frame select from the link, active low, asynchronous |
| sclk_pin | input | 1 | Serial clock from the link, asynchronous |
| din_pin | input | 1 | Serial data from the link, asynchronous |
| abort | input | 1 | System-domain request to void the frame in progress |
| cmd_valid | output | 1 | One-cycle strobe marking a new command |
| cmd_code | output | 3 | Opcode field of the last command |
| cmd_addr | output | 3 | Channel address field of the last command |
| cmd_data | output | 16 | Data field of the last command |

## Verification
A wrong bit count, or a shift register that is not cleared, shows up at the next completed frame. The strobe then comes a serial-clock period too early or too late, or the fields carry bits of the voided frame. The per-cycle model therefore catches it within three system cycles of the strobe. A stuck frame state shows one of two ways: a strobe from clock edges that arrive after a completion or after an abort, or a missing strobe on the next clean frame. Each frame is about two hundred cycles long, so either fault appears within that window.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_SHIFT = 2'd1,
    FR_DONE  = 2'd2
  } fr_state_t;

  function automatic logic edge_fall(input logic prev_v, input logic cur_v);
    return prev_v & ~cur_v;
  endfunction

  function automatic logic edge_rise(input logic prev_v, input logic cur_v);
    return ~prev_v & cur_v;
  endfunction

endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/sfr_edge.sv
module sfr_edge #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  output logic [W-1:0] prev
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= cur;
  end

endmodule

// File: rtl/sfr_shift.sv
module sfr_shift
  import sfr_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int KEEP_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_fall,
  input  logic              sel_rise,
  input  logic              sclk_fall,
  input  logic              din_bit,
  input  logic              abort,
  output logic              frame_done,
  output logic              void_evt,
  output logic [KEEP_W-1:0] frame_word
);

  localparam int                CNT_W    = $clog2(WORD_W);
  localparam logic [CNT_W-1:0]  LAST_IDX = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  fr_state_t          state_q;
  logic [CNT_W-1:0]   bit_cnt;
  logic [KEEP_W-2:0]  shreg;
  logic               in_frame;
  logic               take_bit;

  assign in_frame   = (state_q == FR_SHIFT);
  assign void_evt   = in_frame && (sel_rise || abort);
  assign take_bit   = in_frame && !void_evt && sclk_fall;
  assign frame_done = take_bit && (bit_cnt == LAST_IDX);
  assign frame_word = {shreg, din_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
    end else begin
      unique case (state_q)
        FR_IDLE: begin
          if (sel_fall) begin
            state_q <= FR_SHIFT;
            bit_cnt <= '0;
            shreg   <= '0;
          end
        end
        FR_SHIFT: begin
          if (void_evt) begin
            state_q <= FR_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
          end else if (take_bit) begin
            shreg <= frame_word[KEEP_W-2:0];
            if (frame_done) begin
              state_q <= FR_DONE;
              bit_cnt <= '0;
            end else begin
              bit_cnt <= bit_cnt + CNT_ONE;
            end
          end
        end
        FR_DONE: begin
          if (sel_rise) state_q <= FR_IDLE;
        end
        default: state_q <= FR_IDLE;
      endcase
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= LAST_IDX); // R4
  AST_VOID_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    void_evt |=> (bit_cnt == '0 && shreg == '0 && state_q == FR_IDLE)); // R9
  AST_VOID_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    void_evt |-> !frame_done); // R5
  AST_ABORT_VOIDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && abort) |=> (state_q == FR_IDLE)); // R6
  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FR_DONE) |-> !frame_done); // R7
  AST_FRESH_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FR_IDLE && !sel_fall) |=> (state_q != FR_SHIFT)); // R8
  AST_ONE_HOT_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_done, void_evt})); // R5

endmodule

// File: rtl/sfr_cmd_rx.sv
module sfr_cmd_rx
  import sfr_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int CMD_W       = 3,
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_pin,
  input  logic              sclk_pin,
  input  logic              din_pin,
  input  logic              abort,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);

  localparam int KEEP_W = CMD_W + ADDR_W + DATA_W;

  function automatic logic [CMD_W-1:0] pick_code(input logic [KEEP_W-1:0] w);
    return w[KEEP_W-1 -: CMD_W];
  endfunction

  function automatic logic [ADDR_W-1:0] pick_addr(input logic [KEEP_W-1:0] w);
    return w[DATA_W +: ADDR_W];
  endfunction

  function automatic logic [DATA_W-1:0] pick_data(input logic [KEEP_W-1:0] w);
    return w[DATA_W-1:0];
  endfunction

  // bit order of the synchronized bundle: {select, serial clock, data}
  logic [2:0] pins_s;
  logic [1:0] ctl_prev;
  logic       sel_s, sclk_s, din_s;
  logic       sel_fall, sel_rise, sclk_fall;
  logic       frame_done, void_evt;
  logic [KEEP_W-1:0] frame_word;

  sfr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sel_n_pin, sclk_pin, din_pin}),
    .q     (pins_s)
  );

  assign sel_s  = pins_s[2];
  assign sclk_s = pins_s[1];
  assign din_s  = pins_s[0];

  sfr_edge #(.W(2), .RST_VAL(2'b10)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .cur   ({sel_s, sclk_s}),
    .prev  (ctl_prev)
  );

  assign sel_fall  = edge_fall(ctl_prev[1], sel_s);
  assign sel_rise  = edge_rise(ctl_prev[1], sel_s);
  assign sclk_fall = edge_fall(ctl_prev[0], sclk_s);

  sfr_shift #(.WORD_W(WORD_W), .KEEP_W(KEEP_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_fall   (sel_fall),
    .sel_rise   (sel_rise),
    .sclk_fall  (sclk_fall),
    .din_bit    (din_s),
    .abort      (abort),
    .frame_done (frame_done),
    .void_evt   (void_evt),
    .frame_word (frame_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= frame_done;
      if (frame_done) begin
        cmd_code <= pick_code(frame_word);
        cmd_addr <= pick_addr(frame_word);
        cmd_data <= pick_data(frame_word);
      end
    end
  end

  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> cmd_valid); // R4
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R4
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> ($stable(cmd_code) && $stable(cmd_addr) && $stable(cmd_data))); // R10
  AST_VOID_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    void_evt |=> !cmd_valid); // R6

endmodule

// File: tb/sfr_cmd_rx_test.sv
module sfr_cmd_rx_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1;
  logic        sclk = 1'b1;
  logic        din = 1'b0;
  logic        abort = 1'b0;
  logic        cmd_valid;
  logic [2:0]  cmd_code;
  logic [2:0]  cmd_addr;
  logic [15:0] cmd_data;

  int    n_checks = 0;
  int    n_fail = 0;
  int    strobes = 0;
  bit    finished = 0;
  string cur_tag = "R1";

  sfr_cmd_rx uut (
    .clk(clk), .rst_n(rst_n), .sel_n_pin(sel_n), .sclk_pin(sclk),
    .din_pin(din), .abort(abort), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [2:0]  hist[$];        // pin samples {sel, sclk, din}, oldest first
  int          m_state = 0;    // 0 waiting, 1 collecting, 2 finished
  int          m_count = 0;
  logic [23:0] m_word = '0;
  bit          e_valid = 0;
  int          e_code = 0, e_addr = 0, e_data = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{3'b100, 3'b100, 3'b100};
      m_state = 0; m_count = 0; m_word = '0;
      e_valid = 0; e_code = 0; e_addr = 0; e_data = 0;
    end else begin
      logic [2:0] o, c;
      o = hist[0];
      c = hist[1];
      e_valid = 0;
      if (m_state == 0) begin
        if (o[2] && !c[2]) begin m_state = 1; m_count = 0; m_word = '0; end
      end else if (m_state == 1) begin
        if ((!o[2] && c[2]) || abort) begin
          m_state = 0; m_count = 0; m_word = '0;
        end else if (o[1] && !c[1]) begin
          m_word = {m_word[22:0], c[0]};
          m_count++;
          if (m_count == 24) begin
            e_valid = 1;
            e_code = int'(m_word >> 19) % 8;
            e_addr = int'(m_word >> 16) % 8;
            e_data = int'(m_word) % 65536;
            m_state = 2;
          end
        end
      end else begin
        if (!o[2] && c[2]) m_state = 0;
      end
      hist.push_back({sel_n, sclk, din});
      void'(hist.pop_front());
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (cmd_valid) strobes++;
      chk(cmd_valid == e_valid, cur_tag, "cmd_valid", int'(cmd_valid), int'(e_valid));
      chk(int'(cmd_code) == e_code, cur_tag, "cmd_code", int'(cmd_code), e_code);
      chk(int'(cmd_addr) == e_addr, cur_tag, "cmd_addr", int'(cmd_addr), e_addr);
      chk(int'(cmd_data) == e_data, cur_tag, "cmd_data", int'(cmd_data), e_data);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_frame();
    sel_n = 1'b0; tick(HALF_SCLK);
  endtask

  task automatic close_frame();
    tick(HALF_SCLK); sel_n = 1'b1; tick(HALF_SCLK + 2);
  endtask

  task automatic send_bits(input logic [23:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      din = w[23 - (i % 24)];
      tick(HALF_SCLK);
      sclk = 1'b0;
      tick(HALF_SCLK);
      sclk = 1'b1;
    end
  endtask

  task automatic check_fields(input logic [23:0] w, input string tag);
    chk(int'(cmd_code) == int'(w[21:19]), tag, "code field", int'(cmd_code), int'(w[21:19]));
    chk(int'(cmd_addr) == int'(w[18:16]), tag, "addr field", int'(cmd_addr), int'(w[18:16]));
    chk(int'(cmd_data) == int'(w[15:0]),  tag, "data field", int'(cmd_data), int'(w[15:0]));
  endtask

  task automatic full_frame(input logic [23:0] w, input string tag);
    int s0;
    s0 = strobes;
    cur_tag = tag;
    open_frame();
    send_bits(w, 24);
    close_frame();
    chk(strobes - s0 == 1, tag, "strobe count", strobes - s0, 1);
    check_fields(w, tag);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    int s0;
    logic [23:0] w;
    tick(5);
    rst_n = 1'b1;
    tick(2);
    // R1: reset values
    chk(cmd_valid == 1'b0, "R1", "valid after reset", int'(cmd_valid), 0);
    chk(cmd_code == 3'd0 && cmd_addr == 3'd0 && cmd_data == 16'd0, "R1", "fields after reset",
        int'({cmd_code, cmd_addr, cmd_data}), 0);

    // R2/R3: MSB first, leading bits dropped
    full_frame(24'hC81234, "R3");
    full_frame(24'h3F5A5A, "R2");

    // R7: select held low after completion, extra clock edges
    s0 = strobes; cur_tag = "R7";
    w = 24'h15BEEF;
    open_frame(); send_bits(w, 24); send_bits(24'hFFFFFF, 6); close_frame();
    chk(strobes - s0 == 1, "R7", "strobes with trailing clocks", strobes - s0, 1);
    check_fields(w, "R7");

    // R5: frame cut at 23 bits, fields keep last command (R10)
    s0 = strobes; cur_tag = "R5";
    open_frame(); send_bits(24'h2A0F0F, 23); close_frame();
    chk(strobes - s0 == 0, "R5", "strobes of short frame", strobes - s0, 0);
    check_fields(w, "R10");

    // R9: next clean frame is unaffected by the partial one
    full_frame(24'h0C0001, "R9");

    // R6: abort mid-frame, then clocks with select still low (R8)
    s0 = strobes; cur_tag = "R6";
    open_frame(); send_bits(24'hFFFFFF, 10);
    abort = 1'b1; tick(1); abort = 1'b0;
    cur_tag = "R8";
    send_bits(24'hFFFFFF, 30);
    close_frame();
    chk(strobes - s0 == 0, "R6", "strobes after abort", strobes - s0, 0);
    check_fields(24'h0C0001, "R10");

    // R8: clocking with select high
    s0 = strobes; cur_tag = "R8";
    send_bits(24'hA5A5A5, 26); tick(6);
    chk(strobes - s0 == 0, "R8", "strobes with select high", strobes - s0, 0);
    full_frame(24'h3A8001, "R9");

    // R4: assorted words
    for (int k = 0; k < 6; k++) begin
      w = 24'($urandom);
      full_frame(w, "R4");
    end
    full_frame(24'h000000, "R3");
    full_frame(24'hFFFFFF, "R3");

    tick(10);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule